// File: doc/BRIEF.md
# Multi-Port Transmit Host Write Interface

This block is the host-facing write side of a four-port transmit path. A host bus presents one 32-bit packet word per clock, together with four lane-valid flags, an end-of-frame marker and a 2-bit destination port number. A word is accepted only on a rising edge where both the interface enable and the write enable are high. Each accepted word goes into the FIFO of its destination port with its lane flags and frame tag. The downstream transmit logic drains each FIFO through a simple fall-through read port.

A configuration bit selects the host's byte-lane order. Words are always stored with frame byte 0 in the least significant lane. This bit is sampled only when no packet is open on any port. The interface enable also acts as the output enable of the ready and retry status pins. For the selected port, ready means there is room in its FIFO, and retry means that port's overflow flag.

Top module: `tx_host_wr_if`

## Requirements
- R1: A word is captured only on a rising edge where `tx_if_en` and `tx_wr_en` are both 1. It does not matter whether `tx_wr_en` rose together with `tx_if_en` or later. On any other edge no FIFO changes.
- R2: A captured word is stored in the FIFO whose index equals `port_sel` on the capturing edge (0 to 3). The other FIFOs are unchanged.
- R3: The stored frame tag (`rd_eof` bit of the port) equals `wr_eof` on the capturing edge. Idle cycles with either enable low may fall inside a packet. Back-to-back writes with `tx_wr_en` held high may span the end of one packet and the start of the next.
- R4: Each stored word keeps its four lane-valid flags (`rd_be`, bit k marks bits 8k+7:8k of `rd_data` as valid).
- R5: A write attempt with `wr_be` equal to 4'b1111 is not stored. `illegal_wr` is 1 for exactly the cycle after that edge and 0 otherwise.
- R6: `status_oe` equals `tx_if_en`. `tx_rdy` is 1 when the FIFO of `port_sel` is not full. `tx_ret` equals the overflow flag of `port_sel`.
- R7: In little-endian mode (`big_endian_cfg`=0, the reset state), data and lane flags are stored unchanged.
- R8: In big-endian mode, host lane k is stored in lane 3-k: data bits 31:24 go to 7:0, and so on. `wr_be` bit k is stored as bit 3-k.
- R9: The byte order in force is taken from `big_endian_cfg` only while no packet is open on any port. A packet is open from a non-final captured word until its final word. A change of the bit during an open packet takes effect after all ports have closed their packets.
- R10: Each FIFO holds 16 words. A legal write to a full FIFO is dropped and sets that port's `tx_ovf` bit, which stays set until reset.
- R11: Each FIFO returns words in write order. `rd_valid[p]` is 1 while port p holds data, and `rd_en[p]` removes the head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge capture |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_if_en | input | 1 | Transmit interface enable, also status output enable |
| tx_wr_en | input | 1 | Transmit write enable |
| port_sel | input | 2 | Destination port of the current word |
| wr_data | input | 32 | Packet data word |
| wr_be | input | 4 | Lane-valid flags of the word |
| wr_eof | input | 1 | Marks the last word of a packet |
| big_endian_cfg | input | 1 | Byte-order configuration, 1 = big-endian |
| tx_rdy | output | 1 | Selected port's FIFO has room |
| tx_ret | output | 1 | Selected port's overflow flag |
| status_oe | output | 1 | Drive enable for tx_rdy and tx_ret |
| illegal_wr | output | 1 | One-cycle flag after a write with all lane flags set |
| tx_ovf | output | 4 | Sticky per-port overflow flags |
| rd_en | input | 4 | Per-port head pop |
| rd_valid | output | 4 | Per-port FIFO not empty |
| rd_data | output | 128 | Head data, port p in bits 32p+31:32p |
| rd_be | output | 16 | Head lane flags, port p in bits 4p+3:4p |
| rd_eof | output | 4 | Head frame tag per port |

## Verification
On every cycle, the assertions check four things. A port's FIFO only becomes non-empty after a qualified legal write to that port. The illegal-write flag only follows an all-ones write attempt. Overflow flags never clear, and a FIFO only empties through its own pop. They also check that the latched byte order holds still while any packet is open. Other behaviour depends on stored content and on sequences, and only the directed scenarios show it. This covers data and lane-flag reversal, frame tags across gaps and back-to-back packets, the moment a byte-order change takes effect, and first-in order up to the depth with the seventeenth word dropped.

// File: rtl/txh_pkg.sv
// Shared constants and the stored word type of the transmit host write path.
// Assumes byte-wide lanes; the lane count fixes the data width.
package txh_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;

    typedef struct packed {
        logic              eof;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } txh_word_t;
endpackage

// File: rtl/tx_lane_order.sv
// Maps host byte lanes to stored lanes: straight through in little-endian
// mode, mirrored (lane k to lane LANES-1-k) in big-endian mode.
// Assumes purely combinational use ahead of the FIFO write.
module tx_lane_order
    import txh_pkg::*;
(
    input  logic              big_mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_be,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_be
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int SRC = LANES - 1 - k;
        // Select either the same or the mirrored host lane for lane k.
        always_comb begin
            out_data[k*BYTE_W +: BYTE_W] = big_mode ? in_data[SRC*BYTE_W +: BYTE_W]
                                                    : in_data[k*BYTE_W +: BYTE_W];
            out_be[k] = big_mode ? in_be[SRC] : in_be[k];
        end
    end
endmodule

// File: rtl/tx_port_fifo.sv
// One per-port transmit buffer with a fall-through head.
// Assumes the caller never pushes while full; a pop while empty is ignored.
module tx_port_fifo
    import txh_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  txh_word_t din,
    input  logic      pop,
    output txh_word_t dout,
    output logic      not_empty,
    output logic      full
);
    localparam int AW = $clog2(DEPTH);

    txh_word_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_pop;

    assign do_pop    = pop && (count != '0);
    assign not_empty = (count != '0);
    assign full      = (count == (AW+1)'(DEPTH));
    assign dout      = mem[rd_ptr];

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/tx_host_wr_if.sv
// Host write front end for a multi-port transmit path: qualifies writes with
// two enables, screens the lane flags, applies the byte order and steers the
// word into the FIFO named by the port select. Assumes one clock domain and a
// host that keeps port_sel, data and flags valid on every qualified edge.
module tx_host_wr_if
    import txh_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 16,
    localparam int PSW   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_if_en,
    input  logic                     tx_wr_en,
    input  logic [PSW-1:0]           port_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [LANES-1:0]         wr_be,
    input  logic                     wr_eof,
    input  logic                     big_endian_cfg,
    output logic                     tx_rdy,
    output logic                     tx_ret,
    output logic                     status_oe,
    output logic                     illegal_wr,
    output logic [NPORTS-1:0]        tx_ovf,
    input  logic [NPORTS-1:0]        rd_en,
    output logic [NPORTS-1:0]        rd_valid,
    output logic [NPORTS*DATA_W-1:0] rd_data,
    output logic [NPORTS*LANES-1:0]  rd_be,
    output logic [NPORTS-1:0]        rd_eof
);
    logic              wr_strobe, be_bad, good_wr;
    logic              endian_q, mode_big, pkt_any;
    logic [NPORTS-1:0] pkt_open, full, hit;
    txh_word_t         in_word;
    txh_word_t         head [NPORTS];

    assign wr_strobe = tx_if_en && tx_wr_en;
    assign be_bad    = (wr_be == '1);
    assign good_wr   = wr_strobe && !be_bad;
    assign pkt_any   = |pkt_open;
    assign mode_big  = pkt_any ? endian_q : big_endian_cfg;
    assign in_word.eof = wr_eof;

    tx_lane_order u_order (
        .big_mode (mode_big),
        .in_data  (wr_data),
        .in_be    (wr_be),
        .out_data (in_word.data),
        .out_be   (in_word.be)
    );

    // Latch the byte order only at a point where every port is between packets.
    always_ff @(posedge clk) begin
        if (!rst_n)       endian_q <= 1'b0;
        else if (!pkt_any) endian_q <= big_endian_cfg;
    end

    // One-cycle flag for a write attempt with every lane flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_wr <= 1'b0;
        else        illegal_wr <= wr_strobe && be_bad;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign hit[p] = good_wr && (port_sel == PSW'(p));

        // Track whether a packet has started but not yet ended on this port.
        always_ff @(posedge clk) begin
            if (!rst_n)      pkt_open[p] <= 1'b0;
            else if (hit[p]) pkt_open[p] <= !wr_eof;
        end

        // Sticky flag for a legal write that found the FIFO full.
        always_ff @(posedge clk) begin
            if (!rst_n)                 tx_ovf[p] <= 1'b0;
            else if (hit[p] && full[p]) tx_ovf[p] <= 1'b1;
        end

        tx_port_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (hit[p] && !full[p]),
            .din       (in_word),
            .pop       (rd_en[p]),
            .dout      (head[p]),
            .not_empty (rd_valid[p]),
            .full      (full[p])
        );

        assign rd_data[p*DATA_W +: DATA_W] = head[p].data;
        assign rd_be[p*LANES +: LANES]     = head[p].be;
        assign rd_eof[p]                   = head[p].eof;
    end

    assign status_oe = tx_if_en;
    assign tx_rdy    = !full[port_sel];
    assign tx_ret    = tx_ovf[port_sel];
endmodule

// File: rtl/tx_host_wr_if_chk.sv
// Cycle-level checker for the transmit host write interface, bound to the top.
// Assumes the top's port widths at their default parameters.
module tx_host_wr_if_chk #(
    parameter int NPORTS = 4,
    parameter int PSW    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_if_en,
    input logic              tx_wr_en,
    input logic [PSW-1:0]    port_sel,
    input logic [3:0]        wr_be,
    input logic              illegal_wr,
    input logic [NPORTS-1:0] tx_ovf,
    input logic [NPORTS-1:0] rd_en,
    input logic [NPORTS-1:0] rd_valid,
    input logic              endian_q,
    input logic              pkt_any
);
    assert_illegal_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal_wr) |-> $past(tx_if_en && tx_wr_en && wr_be == 4'hF));

    assert_order_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_any |=> $stable(endian_q));

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        assert_fill_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_valid[p]) |-> $past(tx_if_en && tx_wr_en && wr_be != 4'hF
                                         && port_sel == PSW'(p)));

        assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            tx_ovf[p] |=> tx_ovf[p]);

        assert_drain_by_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rd_valid[p]) |-> $past(rd_en[p]));
    end
endmodule

bind tx_host_wr_if tx_host_wr_if_chk #(.NPORTS(NPORTS), .PSW(PSW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_if_en   (tx_if_en),
    .tx_wr_en   (tx_wr_en),
    .port_sel   (port_sel),
    .wr_be      (wr_be),
    .illegal_wr (illegal_wr),
    .tx_ovf     (tx_ovf),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .endian_q   (endian_q),
    .pkt_any    (pkt_any)
);

// File: tb/tb_tx_host_wr_if.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled on
// the falling edge.
module tb_tx_host_wr_if;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_if_en = 1'b0, tx_wr_en = 1'b0, wr_eof = 1'b0, big_endian_cfg = 1'b0;
    logic [1:0]   port_sel = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_be = '0;
    logic [3:0]   rd_en = '0;
    logic         tx_rdy, tx_ret, status_oe, illegal_wr;
    logic [3:0]   tx_ovf, rd_valid, rd_eof;
    logic [127:0] rd_data;
    logic [15:0]  rd_be;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tx_host_wr_if dut (
        .clk(clk), .rst_n(rst_n), .tx_if_en(tx_if_en), .tx_wr_en(tx_wr_en),
        .port_sel(port_sel), .wr_data(wr_data), .wr_be(wr_be), .wr_eof(wr_eof),
        .big_endian_cfg(big_endian_cfg), .tx_rdy(tx_rdy), .tx_ret(tx_ret),
        .status_oe(status_oe), .illegal_wr(illegal_wr), .tx_ovf(tx_ovf),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_be(rd_be),
        .rd_eof(rd_eof)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One qualified write; leaves tx_if_en high and drops tx_wr_en afterwards.
    task automatic wr(input logic [1:0] p, input logic [31:0] d, input logic [3:0] be, input logic eof);
        tx_if_en = 1'b1; tx_wr_en = 1'b1; port_sel = p; wr_data = d; wr_be = be; wr_eof = eof;
        tick();
        tx_wr_en = 1'b0; wr_eof = 1'b0;
    endtask

    // Check the head of port p, then pop it.
    task automatic pop(input int p, input logic [31:0] d, input logic [3:0] be, input logic eof, input string req);
        check({req, " valid"}, 32'(rd_valid[p]), 32'd1);
        check({req, " data"}, rd_data[p*32 +: 32], d);
        check({req, " be"}, 32'(rd_be[p*4 +: 4]), 32'(be));
        check({req, " eof"}, 32'(rd_eof[p]), 32'(eof));
        rd_en[p] = 1'b1;
        tick();
        rd_en[p] = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 ovf after reset", 32'(tx_ovf), 32'h0);
        check("R11 empty after reset", 32'(rd_valid), 32'h0);
        check("R5 no flag after reset", 32'(illegal_wr), 32'h0);
        check("R6 oe low", 32'(status_oe), 32'h0);
    endtask

    task automatic t_gating();
        tx_if_en = 1'b0; tx_wr_en = 1'b1; port_sel = 2'd0; wr_data = 32'hDEAD0001; wr_be = 4'h1;
        tick();
        check("R1 write enable alone", 32'(rd_valid), 32'h0);
        tx_if_en = 1'b1; tx_wr_en = 1'b0;
        tick();
        check("R1 interface enable alone", 32'(rd_valid), 32'h0);
        check("R6 oe follows enable", 32'(status_oe), 32'h1);
        check("R6 ready on empty port", 32'(tx_rdy), 32'h1);
        wr(2'd0, 32'h11223344, 4'h7, 1'b1);
        check("R1 both enables write", 32'(rd_valid), 32'h1);
        pop(0, 32'h11223344, 4'h7, 1'b1, "R7 little-endian passthrough");
        tx_if_en = 1'b0;
        tick();
        check("R6 oe released", 32'(status_oe), 32'h0);
    endtask

    task automatic t_steer();
        wr(2'd1, 32'hA1A1A1A1, 4'h3, 1'b1);
        wr(2'd3, 32'hB3B3B3B3, 4'hC, 1'b1);
        check("R2 ports 1 and 3 only", 32'(rd_valid), 32'hA);
        pop(1, 32'hA1A1A1A1, 4'h3, 1'b1, "R2 R4 port1");
        pop(3, 32'hB3B3B3B3, 4'hC, 1'b1, "R2 R4 port3");
    endtask

    task automatic t_frames();
        wr(2'd2, 32'h20000000, 4'h1, 1'b0);
        tx_if_en = 1'b0;
        tick(); tick();
        wr(2'd2, 32'h20000001, 4'h2, 1'b1);
        // Back-to-back: write enable held high across a packet boundary.
        tx_wr_en = 1'b1; port_sel = 2'd2; wr_data = 32'h20000002; wr_be = 4'h4; wr_eof = 1'b1;
        tick();
        wr_data = 32'h20000003; wr_be = 4'h8; wr_eof = 1'b0;
        tick();
        wr_data = 32'h20000004; wr_be = 4'h5; wr_eof = 1'b1;
        tick();
        tx_wr_en = 1'b0; wr_eof = 1'b0;
        pop(2, 32'h20000000, 4'h1, 1'b0, "R3 first word");
        pop(2, 32'h20000001, 4'h2, 1'b1, "R3 after gap");
        pop(2, 32'h20000002, 4'h4, 1'b1, "R3 one-word packet");
        pop(2, 32'h20000003, 4'h8, 1'b0, "R3 next packet start");
        pop(2, 32'h20000004, 4'h5, 1'b1, "R3 next packet end");
        check("R11 drained", 32'(rd_valid), 32'h0);
    endtask

    task automatic t_illegal();
        wr(2'd1, 32'hFFFF0000, 4'hF, 1'b1);
        check("R5 flag after all-ones", 32'(illegal_wr), 32'h1);
        check("R5 not stored", 32'(rd_valid), 32'h0);
        tick();
        check("R5 flag one cycle", 32'(illegal_wr), 32'h0);
    endtask

    task automatic t_endian();
        big_endian_cfg = 1'b1;
        wr(2'd0, 32'h11223344, 4'h1, 1'b0);
        big_endian_cfg = 1'b0;
        wr(2'd0, 32'hAABBCCDD, 4'h3, 1'b1);
        wr(2'd0, 32'h01020304, 4'h1, 1'b1);
        pop(0, 32'h44332211, 4'h8, 1'b0, "R8 lanes reversed");
        pop(0, 32'hDDCCBBAA, 4'hC, 1'b1, "R9 order held in packet");
        pop(0, 32'h01020304, 4'h1, 1'b1, "R9 new order at boundary");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 16; i++) wr(2'd3, 32'h30000000 + 32'(i), 4'h1, 1'b1);
        check("R10 not ready when full", 32'(tx_rdy), 32'h0);
        check("R10 no overflow yet", 32'(tx_ovf), 32'h0);
        wr(2'd3, 32'h3FFFFFFF, 4'h1, 1'b1);
        check("R10 overflow set", 32'(tx_ovf), 32'h8);
        check("R6 retry shows overflow", 32'(tx_ret), 32'h1);
        for (int i = 0; i < 16; i++) pop(3, 32'h30000000 + 32'(i), 4'h1, 1'b1, "R11 order");
        check("R10 extra word dropped", 32'(rd_valid), 32'h0);
        check("R10 overflow sticky", 32'(tx_ovf), 32'h8);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_gating();
        t_steer();
        t_frames();
        t_illegal();
        t_endian();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule